// File: doc/BRIEF.md
# Register-Mapped Pad Routing Crossbar

This block sits between a set of internal signal sources and a row of external pads. Each pad owns one byte-wide control register in a small bank. The register chooses which source drives the pad, whether the pad drives at all, and a data bit for software-driven use. It also reports the live level seen on the pad. A simple byte port gives access to the bank: address, write data, write strobe and combinational read data. A host bus bridge outside this block turns serial transactions into accesses on that port.

A pad can take its value from four kinds of place:
- one of 26 internal lines, such as UART transmit, RTS and transmit-enable signals;
- one of four clock inputs;
- its own register data bit, which is GPIO mode;
- a constant 0, when the stored select is zero.

A write whose select field is zero updates the enable and data bits but leaves the routing as it was. Software can therefore toggle a GPIO pad or gate a routed pad without first reading its select value. Each pad is routed on its own, independently of all the others.

Top module: `pin_xbar`

## Requirements
- R1: A read of a mapped pad register returns one byte. Bit 0 is the output-enable bit, bit 1 is the data bit, bit 2 is the synchronized pad input, and bits 7:3 are the 5-bit select.
- R2: A write whose bits 7:3 are 0 leaves the stored select unchanged. Bits 0 and 1 are still written from that byte.
- R3: A stored select of 31 is GPIO mode: the pad output equals the register's data bit.
- R4: A stored select from 27 to 30 drives the pad from clock input `clk_src[select-27]`.
- R5: A stored select from 1 to 26 drives the pad from `src_in[select-1]`. Every pad follows its own select, and a write to one pad changes no other pad.
- R6: `pad_oe` of a pad equals its output-enable bit. When that bit is 0, the pad does not drive, whatever the select.
- R7: Register address N (0 to 12) controls pad N.
- R8: Bit 2 reads the pad level through a two-flop synchronizer. A pad change shows on a read after the second rising edge, not after the first. Writes to bit 2 are ignored.
- R9: Reads from any address above 12 return 0x00. Writes to those addresses change no register and no pad output.
- R10: Reset clears every output-enable and data bit and loads each pad's select from the `DEFAULT_SEL` parameter, 5 bits per pad, with pad 0 in the lowest bits.
- R11: A write takes effect at the rising edge on which the strobe is sampled. Read data follows the address combinationally, so it shows the old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| src_in | input | 26 | Internal sources; bit k is select k+1 |
| clk_src | input | 4 | Clock sources; bit k is select 27+k |
| pad_in | input | NUM_PADS (13) | Levels sampled from the pads |
| pad_out | output | NUM_PADS (13) | Pad output values |
| pad_oe | output | NUM_PADS (13) | Pad output enables |

## Verification
The bench builds the block with its default parameters: 13 pads, 8-bit addresses and a mixed set of reset selects. With that size, every select value from 1 to 31 can be written to every pad. Each pad is then checked against two complementary source and clock patterns, with the whole pad vector compared so that any leak between pads shows. The 8-bit address also makes it cheap to write and read all 243 unmapped addresses. The timing of the synchronizer and of a write is checked edge by edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int SEL_W    = 5;
  localparam int NUM_SRC  = 26;
  localparam int NUM_CLK  = 4;
  localparam int REG_W    = 8;
  localparam logic [SEL_W-1:0] SEL_KEEP = 5'd0;
  localparam logic [SEL_W-1:0] SEL_CLK0 = 5'd27;
  localparam logic [SEL_W-1:0] SEL_GPIO = 5'd31;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             data;
    logic             oe;
  } pad_ctrl_t;

  function automatic logic [REG_W-1:0] reg_view(input pad_ctrl_t c, input logic in_lvl);
    return {c.sel, in_lvl, c.data, c.oe};
  endfunction

  function automatic logic sel_is_src(input logic [SEL_W-1:0] s);
    return (s != SEL_KEEP) && (s < SEL_CLK0);
  endfunction

  function automatic logic sel_is_clk(input logic [SEL_W-1:0] s);
    return (s >= SEL_CLK0) && (s != SEL_GPIO);
  endfunction

  function automatic logic [SEL_W-1:0] src_index(input logic [SEL_W-1:0] s);
    return s - 5'd1;
  endfunction

  function automatic logic [1:0] clk_index(input logic [SEL_W-1:0] s);
    logic [SEL_W-1:0] d;
    d = s - SEL_CLK0;
    return d[1:0];
  endfunction
endpackage

// File: rtl/xbar_sync.sv
module xbar_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/xbar_pad_reg.sv
module xbar_pad_reg
  import xbar_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEF_SEL = SEL_GPIO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output pad_ctrl_t        ctrl
);
  logic [SEL_W-1:0] new_sel;
  logic             keep_sel;

  assign new_sel  = wdata[REG_W-1:3];
  assign keep_sel = (new_sel == SEL_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.oe   <= 1'b0;
      ctrl.data <= 1'b0;
      ctrl.sel  <= DEF_SEL;
    end else if (wr_en) begin
      ctrl.oe   <= wdata[0];
      ctrl.data <= wdata[1];
      if (!keep_sel) ctrl.sel <= new_sel;
    end
  end
endmodule

// File: rtl/xbar_pad_mux.sv
module xbar_pad_mux
  import xbar_pkg::*;
(
  input  pad_ctrl_t          ctrl,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_CLK-1:0] clk_src,
  output logic               pad_out,
  output logic               pad_oe
);
  always_comb begin
    pad_out = 1'b0;
    if (ctrl.sel == SEL_GPIO)       pad_out = ctrl.data;
    else if (sel_is_clk(ctrl.sel))  pad_out = clk_src[clk_index(ctrl.sel)];
    else if (sel_is_src(ctrl.sel))  pad_out = src_in[src_index(ctrl.sel)];
  end

  assign pad_oe = ctrl.oe;
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_PADS = 13,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_PADS*SEL_W-1:0] DEFAULT_SEL = {
    5'd31, 5'd27, 5'd10, 5'd9, 5'd8, 5'd7, 5'd6,
    5'd5,  5'd4,  5'd3,  5'd2, 5'd1, 5'd31}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                reg_we,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_SRC-1:0]  src_in,
  input  logic [NUM_CLK-1:0]  clk_src,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  localparam int CTRL_W = NUM_PADS * SEL_W;

  // named internal events for the checker
  logic [NUM_PADS-1:0] wr_hit;
  logic [NUM_PADS-1:0] in_sync;
  logic [NUM_PADS-1:0] oe_vec;
  logic [NUM_PADS-1:0] data_vec;
  logic [CTRL_W-1:0]   sel_flat;
  logic [REG_W-1:0]    view [NUM_PADS];

  xbar_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (in_sync)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    pad_ctrl_t ctrl;

    assign wr_hit[i] = reg_we && (reg_addr == ADDR_W'(i));

    xbar_pad_reg #(.DEF_SEL(DEFAULT_SEL[i*SEL_W +: SEL_W])) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_hit[i]),
      .wdata(reg_wdata),
      .ctrl (ctrl)
    );

    xbar_pad_mux u_mux (
      .ctrl   (ctrl),
      .src_in (src_in),
      .clk_src(clk_src),
      .pad_out(pad_out[i]),
      .pad_oe (pad_oe[i])
    );

    assign oe_vec[i]                = ctrl.oe;
    assign data_vec[i]              = ctrl.data;
    assign sel_flat[i*SEL_W +: SEL_W] = ctrl.sel;
    assign view[i]                  = reg_view(ctrl, in_sync[i]);
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_PADS; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = view[i];
    end
  end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PADS = 13,
  parameter int ADDR_W   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [REG_W-1:0]          reg_wdata,
  input logic                      reg_we,
  input logic [REG_W-1:0]          reg_rdata,
  input logic [NUM_PADS-1:0]       pad_in,
  input logic [NUM_PADS-1:0]       pad_out,
  input logic [NUM_PADS-1:0]       pad_oe,
  input logic [NUM_PADS-1:0]       wr_hit,
  input logic [NUM_PADS-1:0]       in_sync,
  input logic [NUM_PADS-1:0]       oe_vec,
  input logic [NUM_PADS-1:0]       data_vec,
  input logic [NUM_PADS*SEL_W-1:0] sel_flat
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_PADS - 1);

  logic [1:0] age;
  logic       unmapped;
  logic       keep_wr;

  assign unmapped = reg_addr > TOP_ADDR;
  assign keep_wr  = reg_we && !unmapped && (reg_wdata[7:3] == SEL_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R7: at most one pad register is hit by a write
  p_one_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R2: a zero select on a write keeps all routing
  p_keep_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    keep_wr |=> $stable(sel_flat));

  // R9: unmapped read returns zero
  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (reg_rdata == 8'h00));

  // R9: unmapped write changes no register
  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && unmapped) |=> $stable({oe_vec, data_vec, sel_flat}));

  // R8: the input level lags the pad by two edges
  p_sync_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (in_sync == $past(pad_in, 2)));

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad_chk
    // R6: cleared enable never drives
    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_vec[i] |-> !pad_oe[i]);

    // R3: GPIO mode drives the data bit
    p_gpio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[i*SEL_W +: SEL_W] == SEL_GPIO) |-> (pad_out[i] == data_vec[i]));

    // R11: a nonzero select written lands on the next edge
    p_sel_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && reg_wdata[7:3] != SEL_KEEP)
        |=> (sel_flat[i*SEL_W +: SEL_W] == $past(reg_wdata[7:3])));
  end
endmodule

bind pin_xbar xbar_chk #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_we   (reg_we),
  .reg_rdata(reg_rdata),
  .pad_in   (pad_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .wr_hit   (wr_hit),
  .in_sync  (in_sync),
  .oe_vec   (oe_vec),
  .data_vec (data_vec),
  .sel_flat (sel_flat)
);

// File: tb/sim_pin_xbar.sv
`timescale 1ns/1ps
module sim_pin_xbar;
  localparam int NP = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic [25:0] src_in = '0;
  logic [3:0]  clk_src = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int n_chk = 0;
  int n_fail = 0;

  logic [4:0] m_sel [NP];
  logic       m_oe  [NP];
  logic       m_dat [NP];

  always #2.5 clk = ~clk;

  pin_xbar u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .src_in(src_in), .clk_src(clk_src),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [4:0] def_sel(input int p);
    case (p)
      0: return 5'd31;  1: return 5'd1;   2: return 5'd2;   3: return 5'd3;
      4: return 5'd4;   5: return 5'd5;   6: return 5'd6;   7: return 5'd7;
      8: return 5'd8;   9: return 5'd9;   10: return 5'd10; 11: return 5'd27;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic model_out(input int p);
    int s;
    s = int'(m_sel[p]);
    if (s == 31) return m_dat[p];
    if (s >= 27) return clk_src[s - 27];
    if (s >= 1)  return src_in[s - 1];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v,
                     input string what);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a[7:0]; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < NP) begin
      m_oe[a] = d[0];
      m_dat[a] = d[1];
      if (d[7:3] != 5'd0) m_sel[a] = d[7:3];
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a[7:0];
    #1 v = reg_rdata;
  endtask

  task automatic chk_pads(input string req);
    #1;
    for (int p = 0; p < NP; p++) begin
      chk(req, 32'(pad_out[p]), 32'(model_out(p)), $sformatf("pad_out[%0d]", p));
      chk("R6", 32'(pad_oe[p]), 32'(m_oe[p]), $sformatf("pad_oe[%0d]", p));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] snap [NP];
    logic [NP-1:0] snap_out, snap_oe;
    for (int p = 0; p < NP; p++) begin
      m_sel[p] = def_sel(p); m_oe[p] = 1'b0; m_dat[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 / R1 / R7: reset contents of every register
    for (int p = 0; p < NP; p++) begin
      rd(p, v);
      chk("R10", 32'(v), 32'({def_sel(p), 3'b000}), $sformatf("reset reg %0d", p));
    end
    chk("R10", 32'(pad_oe), 32'(0), "reset pad_oe");

    // R3 R4 R5 R7: every select on every pad, two complementary patterns
    for (int p = 0; p < NP; p++) begin
      for (int s = 1; s <= 31; s++) begin
        logic [7:0] d;
        d = {5'(s), 1'b0, 1'(s & 1), 1'b1};
        wr(p, d);
        rd(p, v);
        chk("R1", 32'(v), 32'(d), $sformatf("readback pad %0d sel %0d", p, s));
        src_in = 26'h2AAAAAA ^ 26'(p * 97 + s);
        clk_src = 4'(s) ^ 4'b0101;
        chk_pads(s == 31 ? "R3" : (s >= 27 ? "R4" : "R5"));
        src_in = ~src_in;
        clk_src = ~clk_src;
        chk_pads(s == 31 ? "R3" : (s >= 27 ? "R4" : "R5"));
      end
    end

    // R2: zero select keeps routing, updates enable and data
    wr(3, 8'h0A);
    wr(3, {5'd0, 3'b010});
    rd(3, v);
    chk("R2", 32'(v), 32'({5'd1, 3'b010}), "sel zero keeps sel 1");
    chk_pads("R2");

    // R6: enable clear never drives, whatever the select
    for (int s = 1; s <= 31; s++) begin
      wr(4, {5'(s), 3'b010});
      chk("R6", 32'(pad_oe[4]), 32'(0), $sformatf("oe clear sel %0d", s));
    end

    // R11: write lands on the edge, read is combinational
    wr(2, {5'd7, 3'b001});
    @(negedge clk);
    reg_addr = 8'd2; reg_wdata = {5'd31, 3'b011}; reg_we = 1'b1;
    #1 chk("R11", 32'(reg_rdata), 32'({5'd7, 3'b001}), "before edge");
    @(posedge clk);
    #1 chk("R11", 32'(reg_rdata), 32'({5'd31, 3'b011}), "after edge");
    @(negedge clk);
    reg_we = 1'b0;
    m_sel[2] = 5'd31; m_oe[2] = 1'b1; m_dat[2] = 1'b1;
    chk_pads("R11");

    // R8: synchronizer lag and write-ignore on bit 2
    rd(5, v);
    @(negedge clk);
    pad_in[5] = 1'b1;
    @(posedge clk);
    #1 chk("R8", 32'(reg_rdata[2]), 32'(0), "input after one edge");
    @(posedge clk);
    #1 chk("R8", 32'(reg_rdata[2]), 32'(1), "input after two edges");
    wr(5, {5'd9, 3'b000});
    rd(5, v);
    chk("R8", 32'(v[2]), 32'(1), "bit2 write 0 ignored");
    wr(6, {5'd9, 3'b100});
    rd(6, v);
    chk("R8", 32'(v[2]), 32'(0), "bit2 write 1 ignored");

    // R9: unmapped addresses
    for (int p = 0; p < NP; p++) rd(p, snap[p]);
    snap_out = pad_out; snap_oe = pad_oe;
    for (int a = NP; a < 256; a++) begin
      wr(a, 8'hFF);
      rd(a, v);
      chk("R9", 32'(v), 32'(0), $sformatf("read addr %0d", a));
    end
    for (int p = 0; p < NP; p++) begin
      rd(p, v);
      chk("R9", 32'(v), 32'(snap[p]), $sformatf("reg %0d after unmapped writes", p));
    end
    chk("R9", 32'(pad_out), 32'(snap_out), "pad_out after unmapped writes");
    chk("R9", 32'(pad_oe), 32'(snap_oe), "pad_oe after unmapped writes");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule